// File: doc/BRIEF.md
# Lockable Region Write Guard

This block sits between a serial-bus front end and a 16K x 8 byte store. It decides, for every byte the front end wants to commit, whether the write may reach the array. Two independent mechanisms can refuse a write.

- **Write-protect pin.** An active-high pin refuses every write.
- **One-time lock.** A sticky lock refuses writes into a 256-byte region at the top of the address space. The lock is armed by one special address-only bus transaction.

The front end reports decoded bus events as a stream: start, device byte, word-address byte, data byte and stop. The guard watches that stream for the lock pattern. When the pattern completes, the guard sets a lock flag that nothing but reset can clear. At reset the flag is loaded from a preload input, which stands in for non-volatile storage.

Commit requests use a valid/ready handshake. The guard never applies back-pressure: `cm_ready` and `ev_ready` are always high. A refused write is therefore still accepted, so the bus engine can acknowledge it as usual, but no write strobe reaches the array.

Top module: `region_write_guard`

## Requirements
- R1: While `rst_n` is low, the lock flag loads the value of `lock_preload`, and `region_locked` shows that value from the first clock edge after reset.
- R2: While `wp` is high, `mem_we` stays low for every address.
- R3: While `wp` is low and the lock is clear, `mem_we` follows `cm_valid` in the same cycle at any address, including 0x3F00-0x3FFF. In that case `mem_addr` equals `cm_addr` and `mem_wdata` equals `cm_data`.
- R4: While the lock is set, a request to any address from 0x3F00 to 0x3FFF gives `mem_we` low. Requests below 0x3F00 still follow the rule in R2 and R3.
- R5: The lock arms on the following sequence, taken only on cycles with `ev_valid` high. The event codes on `ev_kind` are 0 start, 1 device byte, 2 address byte, 3 data byte and 4 stop.
  - a start event;
  - a device-byte event carrying 0xAC;
  - an address-byte event whose bits [7:6] are 11;
  - one more address-byte event with any value;
  - a stop event.
  `region_locked` goes high on the clock edge that takes the stop event.
- R6: The lock does not arm if any of the following holds:
  - the device byte is not 0xAC (for example 0xAD or 0xA0);
  - the first address byte has bits [7:6] other than 11;
  - the number of address bytes is other than two;
  - a data byte appears before the stop;
  - the sequence is not opened by a start.
- R7: Once set, the lock stays set through any later bus traffic or commit requests until the next reset.
- R8: `cm_ready` and `ev_ready` are always high. A refused commit is accepted in the same way as a permitted one.
- R9: `wp` and the lock act independently. The lock arms even while `wp` is high. Lowering `wp` afterwards re-opens writes below 0x3F00 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write-protect pin, high refuses all writes; tie low when unused |
| lock_preload | input | 1 | Lock state loaded during reset |
| ev_valid | input | 1 | Bus event present |
| ev_ready | output | 1 | Always high; events are never stalled |
| ev_kind | input | 3 | Event code: 0 start, 1 device, 2 address, 3 data, 4 stop |
| ev_byte | input | 8 | Byte carried by device, address or data events |
| cm_valid | input | 1 | Commit request present |
| cm_ready | output | 1 | Always high; request accepted even when refused |
| cm_addr | input | 14 | Word address of the byte to commit |
| cm_data | input | 8 | Byte to commit |
| mem_we | output | 1 | Write strobe to the array |
| mem_addr | output | 14 | Address to the array |
| mem_wdata | output | 8 | Data to the array |
| write_ok | output | 1 | The current `cm_addr` may be written |
| region_locked | output | 1 | Lock flag state |

## Verification
The assertions assume `wp`, `cm_valid` and `cm_addr` are stable for the whole cycle in which they are sampled. They also assume every event is a single-cycle pulse of `ev_valid` with a code from 0 to 4. The stimulus meets these assumptions by changing inputs only on falling clock edges and holding `ev_valid` for exactly one cycle per event. Commit outputs are combinational, so the bench checks them shortly after it drives a request. The lock flag is checked one falling edge after the stop event it responds to.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Decoded bus event codes supplied by the serial front end
  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_DEV   = 3'd1,
    EV_ADDR  = 3'd2,
    EV_DATA  = 3'd3,
    EV_STOP  = 3'd4
  } ev_kind_e;

  // Progress through the lock-arming transaction
  typedef enum logic [2:0] {
    TK_IDLE,    // outside any transaction
    TK_DEV,     // start seen, device byte expected
    TK_ADR_HI,  // device matched, first address byte expected
    TK_ADR_LO,  // first address byte matched, second expected
    TK_ARMED,   // both address bytes seen, stop will arm the lock
    TK_DEAD     // pattern broken until next start
  } trk_state_e;

endpackage

// File: rtl/guard_seq_tracker.sv
module guard_seq_tracker
  import guard_pkg::*;
#(
  parameter logic [7:0] LOCK_DEV   = 8'hAC,
  parameter logic [7:0] HI_MASK    = 8'hC0,
  parameter logic [7:0] HI_MATCH   = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       lock_fire
);

  trk_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    lock_fire = 1'b0;
    if (ev_valid) begin
      case (ev_kind)
        EV_START: state_d = TK_DEV;
        EV_DEV: begin
          if (state_q == TK_DEV && ev_byte == LOCK_DEV) state_d = TK_ADR_HI;
          else                                          state_d = TK_DEAD;
        end
        EV_ADDR: begin
          if (state_q == TK_ADR_HI && (ev_byte & HI_MASK) == HI_MATCH)
            state_d = TK_ADR_LO;
          else if (state_q == TK_ADR_LO)
            state_d = TK_ARMED;
          else
            state_d = TK_DEAD;
        end
        EV_DATA: state_d = TK_DEAD;
        EV_STOP: begin
          lock_fire = (state_q == TK_ARMED);
          state_d   = TK_IDLE;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= TK_IDLE;
    else        state_q <= state_d;
  end

  // Armed state is only reached straight from an address byte event
  AST_ARMED_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TK_ARMED && $past(state_q) != TK_ARMED) |->
      ($past(ev_valid) && $past(ev_kind) == EV_ADDR)); // R5

  // A data byte always breaks the pattern
  AST_DATA_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EV_DATA) |=> (state_q == TK_DEAD)); // R6

endmodule

// File: rtl/guard_lock_flag.sv
module guard_lock_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic preload,
  input  logic set,
  output logic locked
);

  always_ff @(posedge clk) begin
    if (!rst_n)   locked <= preload;
    else if (set) locked <= 1'b1;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R7

  AST_LOCK_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !set) |=> !locked); // R6

endmodule

// File: rtl/guard_region_decode.sv
module guard_region_decode #(
  parameter int ADDR_W       = 14,
  parameter int REGION_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region
);

  localparam int OFF_W = $clog2(REGION_BYTES);
  localparam bit POW2  = ((1 << OFF_W) == REGION_BYTES);
  localparam logic [ADDR_W:0] BASE = (ADDR_W + 1)'((1 << ADDR_W) - REGION_BYTES);

  generate
    if (OFF_W >= ADDR_W) begin : g_all
      assign in_region = 1'b1;
    end else if (POW2) begin : g_pow2
      assign in_region = &addr[ADDR_W-1:OFF_W];
    end else begin : g_cmp
      assign in_region = ({1'b0, addr} >= BASE);
    end
  endgenerate

endmodule

// File: rtl/region_write_guard.sv
module region_write_guard
  import guard_pkg::*;
#(
  parameter int         ADDR_W       = 14,
  parameter int         REGION_BYTES = 256,
  parameter logic [7:0] LOCK_DEV     = 8'hAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              lock_preload,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [2:0]        ev_kind,
  input  logic [7:0]        ev_byte,
  input  logic              cm_valid,
  output logic              cm_ready,
  input  logic [ADDR_W-1:0] cm_addr,
  input  logic [7:0]        cm_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              write_ok,
  output logic              region_locked
);

  logic lock_fire;
  logic in_region;

  guard_seq_tracker #(
    .LOCK_DEV (LOCK_DEV),
    .HI_MASK  (8'hC0),
    .HI_MATCH (8'hC0)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_byte   (ev_byte),
    .lock_fire (lock_fire)
  );

  guard_lock_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .preload (lock_preload),
    .set     (lock_fire),
    .locked  (region_locked)
  );

  guard_region_decode #(
    .ADDR_W       (ADDR_W),
    .REGION_BYTES (REGION_BYTES)
  ) u_decode (
    .addr      (cm_addr),
    .in_region (in_region)
  );

  assign ev_ready  = 1'b1;
  assign cm_ready  = 1'b1;
  assign write_ok  = !wp && !(region_locked && in_region);
  assign mem_we    = cm_valid && write_ok;
  assign mem_addr  = cm_addr;
  assign mem_wdata = cm_data;

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !mem_we); // R2

  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp && !region_locked && cm_valid) |-> mem_we); // R3

  AST_REGION_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (region_locked && in_region) |-> !mem_we); // R4

  AST_LOCK_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fire |=> region_locked); // R5

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cm_valid && cm_ready)); // R8

endmodule

// File: tb/test_region_write_guard.sv
module test_region_write_guard;

  localparam logic [2:0] K_START = 3'd0;
  localparam logic [2:0] K_DEV   = 3'd1;
  localparam logic [2:0] K_ADDR  = 3'd2;
  localparam logic [2:0] K_DATA  = 3'd3;
  localparam logic [2:0] K_STOP  = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp = 1'b0;
  logic        lock_preload = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_kind = 3'd0;
  logic [7:0]  ev_byte = 8'h00;
  logic        cm_valid = 1'b0;
  logic        cm_ready;
  logic [13:0] cm_addr = 14'h0;
  logic [7:0]  cm_data = 8'h00;
  logic        mem_we;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        write_ok;
  logic        region_locked;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  region_write_guard i_region_write_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp            (wp),
    .lock_preload  (lock_preload),
    .ev_valid      (ev_valid),
    .ev_ready      (ev_ready),
    .ev_kind       (ev_kind),
    .ev_byte       (ev_byte),
    .cm_valid      (cm_valid),
    .cm_ready      (cm_ready),
    .cm_addr       (cm_addr),
    .cm_data       (cm_data),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .write_ok      (write_ok),
    .region_locked (region_locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pre);
    @(negedge clk);
    lock_preload = pre;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = k;
    ev_byte  = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic try_write(input string tag, input logic [13:0] a, input logic [7:0] d,
                           input logic w, input logic exp_we);
    @(negedge clk);
    wp = w;
    cm_valid = 1'b1;
    cm_addr = a;
    cm_data = d;
    #1;
    check(tag, {31'd0, mem_we}, {31'd0, exp_we});
    check({tag, " R8 ready"}, {31'd0, cm_ready}, 32'd1);
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R1 preload high", {31'd0, region_locked}, 32'd1);
    try_write("R1 R4 region shut from preload", 14'h3F00, 8'h11, 1'b0, 1'b0);
    try_write("R1 low area open", 14'h0000, 8'h12, 1'b0, 1'b1);
    do_reset(1'b0);
    check("R1 preload low", {31'd0, region_locked}, 32'd0);
    check("R8 ev_ready", {31'd0, ev_ready}, 32'd1);
  endtask

  task automatic t_open;
    @(negedge clk);
    wp = 1'b0;
    cm_valid = 1'b1;
    cm_addr = 14'h3FFF;
    cm_data = 8'h5A;
    #1;
    check("R3 region writable when unlocked", {31'd0, mem_we}, 32'd1);
    check("R3 addr pass", {18'd0, mem_addr}, 32'h3FFF);
    check("R3 data pass", {24'd0, mem_wdata}, 32'h5A);
    @(negedge clk);
    cm_valid = 1'b0;
    #1;
    check("R3 no strobe without request", {31'd0, mem_we}, 32'd0);
    try_write("R3 mid address", 14'h1234, 8'hA5, 1'b0, 1'b1);
  endtask

  task automatic t_wp;
    try_write("R2 wp low address", 14'h0000, 8'h01, 1'b1, 1'b0);
    try_write("R2 wp region address", 14'h3F80, 8'h02, 1'b1, 1'b0);
    check("R2 write_ok low", {31'd0, write_ok}, 32'd0);
    try_write("R2 wp released", 14'h0010, 8'h03, 1'b0, 1'b1);
  endtask

  task automatic t_near_miss;
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAD); send_ev(K_ADDR, 8'hC0);
    send_ev(K_ADDR, 8'h00); send_ev(K_STOP, 8'h00);
    check("R6 read device byte", {31'd0, region_locked}, 32'd0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hA0); send_ev(K_ADDR, 8'hC0);
    send_ev(K_ADDR, 8'h00); send_ev(K_STOP, 8'h00);
    check("R6 other device byte", {31'd0, region_locked}, 32'd0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'h80);
    send_ev(K_ADDR, 8'h00); send_ev(K_STOP, 8'h00);
    check("R6 high bits 10", {31'd0, region_locked}, 32'd0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'hC0);
    send_ev(K_STOP, 8'h00);
    check("R6 one address byte", {31'd0, region_locked}, 32'd0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'hFF);
    send_ev(K_ADDR, 8'h00); send_ev(K_DATA, 8'h33); send_ev(K_STOP, 8'h00);
    check("R6 data byte present", {31'd0, region_locked}, 32'd0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'hC0);
    send_ev(K_ADDR, 8'h00); send_ev(K_ADDR, 8'h00); send_ev(K_STOP, 8'h00);
    check("R6 three address bytes", {31'd0, region_locked}, 32'd0);
    send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'hC0);
    send_ev(K_ADDR, 8'h00); send_ev(K_STOP, 8'h00);
    check("R6 no start", {31'd0, region_locked}, 32'd0);
    try_write("R6 region still open", 14'h3F40, 8'h44, 1'b0, 1'b1);
  endtask

  task automatic t_lock;
    @(negedge clk);
    wp = 1'b1;
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hAC); send_ev(K_ADDR, 8'hC7);
    send_ev(K_ADDR, 8'h9E);
    check("R5 not armed before stop", {31'd0, region_locked}, 32'd0);
    send_ev(K_STOP, 8'h00);
    check("R5 R9 armed with wp high", {31'd0, region_locked}, 32'd1);
  endtask

  task automatic t_after_lock;
    try_write("R4 base of region", 14'h3F00, 8'h01, 1'b0, 1'b0);
    try_write("R4 top of region", 14'h3FFF, 8'h02, 1'b0, 1'b0);
    try_write("R4 R9 just below region", 14'h3EFF, 8'h03, 1'b0, 1'b1);
    try_write("R9 low address open", 14'h0000, 8'h04, 1'b0, 1'b1);
    try_write("R9 wp still blocks below", 14'h3EFF, 8'h05, 1'b1, 1'b0);
    send_ev(K_START, 8'h00); send_ev(K_DEV, 8'hA0); send_ev(K_ADDR, 8'h3F);
    send_ev(K_ADDR, 8'h00); send_ev(K_DATA, 8'h77); send_ev(K_STOP, 8'h00);
    send_ev(K_START, 8'h00);
    check("R7 lock survives traffic", {31'd0, region_locked}, 32'd1);
    try_write("R7 region still shut", 14'h3F10, 8'h06, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_open();
    t_wp();
    t_near_miss();
    t_lock();
    t_after_lock();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule